// File: doc/BRIEF.md
# Byte-Loaded Address Pointer with Staging Latch

This block holds a 16-bit address split into a high byte and a low byte, and it sits on an 8-bit data bus. A processor uses it as a program counter or as a stack or indirect pointer. It answers three codes on a 4-bit register-select bus: one for the high byte, one for the low byte and one for an indirect memory access. Its 16-bit value goes out on the address bus at all times.

Because the bus moves only one byte per access, an 8-bit staging latch makes 16-bit loads and readbacks behave as if they were atomic. A high-byte write goes only into the latch. The following low-byte write loads the low byte and moves the latch into the live high byte on the same clock edge, so the pointer never holds a half-updated address.

On the read side, a low-byte read copies the live high byte into the latch, and a later high-byte read returns that copy. An indirect read uses the current value as the address and then adds one to it. An indirect write first takes one away and uses the result as the address, so a stack built with it grows downward. A 16-bit ripple chain computes the increment and the decrement without an ALU.

Top module: `addr_pair_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the high byte, the low byte and the staging latch, so that `addr` reads 16'h0000 and a high-byte read returns 8'h00.
- R2: A write with the high-byte select (`acc_en`=1, `wr_en`=1) stores `din` into the staging latch only. `addr` is unchanged after the edge.
- R3: A write with the low-byte select loads `din` into `addr[7:0]` and, on the same edge, copies the staging latch into `addr[15:8]`.
- R4: A read with the low-byte select (`acc_en`=1, `wr_en`=0) drives the live low byte on `dout` in that cycle. On the edge that ends the read, it copies the live high byte into the staging latch.
- R5: A read with the high-byte select drives the staging latch on `dout`, not the live high byte.
- R6: An indirect read asserts `mem_rd` and presents the current value on `addr` during the access. After the ending edge, the value is one greater.
- R7: An indirect write asserts `mem_wr` and presents the current value minus one on `addr` during the access. After the ending edge, the stored value equals that decremented address.
- R8: The increment and the decrement ripple across all 16 bits and wrap: 16'hFFFF plus one gives 16'h0000, 16'h0000 minus one gives 16'hFFFF, and a carry from the low byte reaches the high byte.
- R9: A select code that is not one of the three, or any cycle with `acc_en`=0, changes no state, gives `dout`=8'h00, and asserts neither strobe. At most one of `mem_rd` and `mem_wr` is high in any cycle.
- R10: The select codes are parameters. The defaults take the program-counter set: 4'b1011 for the high byte, 4'b1100 for the low byte and 4'b1111 for indirect access. The pointer set 4'b1010, 4'b1101 and 4'b1110 is then foreign to the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | A register access is made in this cycle |
| wr_en | input | 1 | 1 = write to the selected register, 0 = read |
| sel | input | 4 | Register-select code |
| din | input | 8 | Data bus into the block |
| dout | output | 8 | Byte read back (8'h00 when the block is not selected for a byte read) |
| addr | output | 16 | Address bus value |
| mem_rd | output | 1 | Indirect read through this pointer in this cycle |
| mem_wr | output | 1 | Indirect write through this pointer in this cycle |

## Verification
Two functions can fall in the same cycle. In the first case, a low-byte read drives the live low byte onto `dout` while the same edge captures the high byte into the latch. The bench first stages a different byte in the latch, then makes that read, and checks `dout` during the cycle and the high-byte readback afterwards. In the second case, an indirect write presents the decremented address combinationally while the register commits that same decrement. The bench makes back-to-back indirect writes and checks that each access shows an address one below the previous one, including the wrap through zero.

// File: rtl/addr_pair_pkg.sv
package addr_pair_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        AP_IDLE,
        AP_RD_HI,
        AP_WR_HI,
        AP_RD_LO,
        AP_WR_LO,
        AP_RD_IND,
        AP_WR_IND
    } ap_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hold;
    } ap_state_t;

    function automatic logic [WORD_W-1:0] ap_word(input ap_state_t s);
        return {s.hi, s.lo};
    endfunction

endpackage

// File: rtl/ap_decode.sv
module ap_decode
    import addr_pair_pkg::*;
#(
    parameter int              SEL_W   = 4,
    parameter logic [SEL_W-1:0] SEL_HI  = 4'b1011,
    parameter logic [SEL_W-1:0] SEL_LO  = 4'b1100,
    parameter logic [SEL_W-1:0] SEL_IND = 4'b1111
) (
    input  logic             acc_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    output ap_op_e           op
);
    always_comb begin
        op = AP_IDLE;
        if (acc_en) begin
            if (sel == SEL_HI)       op = wr_en ? AP_WR_HI  : AP_RD_HI;
            else if (sel == SEL_LO)  op = wr_en ? AP_WR_LO  : AP_RD_LO;
            else if (sel == SEL_IND) op = wr_en ? AP_WR_IND : AP_RD_IND;
        end
    end
endmodule

// File: rtl/ap_ripple.sv
module ap_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc,
    output logic [W-1:0] dec
);
    logic [W:0] carry;
    logic [W:0] borrow;

    assign carry[0]  = 1'b1;
    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inc[i]      = val[i] ^ carry[i];
        assign carry[i+1]  = val[i] & carry[i];
        assign dec[i]      = val[i] ^ borrow[i];
        assign borrow[i+1] = ~val[i] & borrow[i];
    end
endmodule

// File: rtl/ap_store.sv
module ap_store
    import addr_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ap_op_e            op,
    input  logic [BYTE_W-1:0] din,
    input  logic [WORD_W-1:0] inc,
    input  logic [WORD_W-1:0] dec,
    output ap_state_t         st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            unique case (op)
                AP_WR_HI:  st.hold <= din;
                AP_WR_LO: begin
                    st.lo <= din;
                    st.hi <= st.hold;
                end
                AP_RD_LO:  st.hold <= st.hi;
                AP_RD_IND: {st.hi, st.lo} <= inc;
                AP_WR_IND: {st.hi, st.lo} <= dec;
                default:   st <= st;
            endcase
        end
    end
endmodule

// File: rtl/addr_pair_reg.sv
module addr_pair_reg
    import addr_pair_pkg::*;
#(
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] SEL_HI  = 4'b1011,
    parameter logic [SEL_W-1:0] SEL_LO  = 4'b1100,
    parameter logic [SEL_W-1:0] SEL_IND = 4'b1111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic [WORD_W-1:0] addr,
    output logic              mem_rd,
    output logic              mem_wr
);
    ap_op_e            op;
    ap_state_t         st;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] nxt_up;
    logic [WORD_W-1:0] nxt_dn;

    ap_decode #(
        .SEL_W  (SEL_W),
        .SEL_HI (SEL_HI),
        .SEL_LO (SEL_LO),
        .SEL_IND(SEL_IND)
    ) u_decode (
        .acc_en(acc_en),
        .wr_en (wr_en),
        .sel   (sel),
        .op    (op)
    );

    assign cur = ap_word(st);

    ap_ripple #(.W(WORD_W)) u_ripple (
        .val(cur),
        .inc(nxt_up),
        .dec(nxt_dn)
    );

    ap_store u_store (
        .clk(clk),
        .rst(rst),
        .op (op),
        .din(din),
        .inc(nxt_up),
        .dec(nxt_dn),
        .st (st)
    );

    always_comb begin
        unique case (op)
            AP_RD_HI: dout = st.hold;
            AP_RD_LO: dout = st.lo;
            default:  dout = '0;
        endcase
    end

    assign addr   = (op == AP_WR_IND) ? nxt_dn : cur;
    assign mem_rd = (op == AP_RD_IND);
    assign mem_wr = (op == AP_WR_IND);
endmodule

// File: rtl/addr_pair_reg_chk.sv
module addr_pair_reg_chk #(
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] SEL_HI  = 4'b1011,
    parameter logic [SEL_W-1:0] SEL_LO  = 4'b1100,
    parameter logic [SEL_W-1:0] SEL_IND = 4'b1111
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_en,
    input logic             wr_en,
    input logic [SEL_W-1:0] sel,
    input logic [7:0]       din,
    input logic [7:0]       dout,
    input logic [15:0]      addr,
    input logic             mem_rd,
    input logic             mem_wr
);
    // R1: reset leaves the value at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mem_wr ? addr == 16'hFFFF : addr == 16'h0000));

    // R2: a high-byte write leaves the address untouched
    a_r2_hi_write_staged: assert property (@(posedge clk) disable iff (rst)
        (acc_en && wr_en && sel == SEL_HI) |=> (mem_wr || addr == $past(addr)));

    // R3: a low-byte write lands in the low half of the address
    a_r3_lo_write_loads: assert property (@(posedge clk) disable iff (rst)
        (acc_en && wr_en && sel == SEL_LO) |=> (mem_wr || addr[7:0] == $past(din)));

    // R5: high-byte readback right after a high-byte write returns the staged byte
    a_r5_hi_read_latch: assert property (@(posedge clk) disable iff (rst)
        (acc_en && wr_en && sel == SEL_HI) ##1 (acc_en && !wr_en && sel == SEL_HI)
        |-> dout == $past(din));

    // R6: an indirect read advances the pointer by one
    a_r6_post_increment: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_wr || addr == $past(addr) + 16'd1));

    // R7: the pre-decremented address stays as the new value
    a_r7_pre_decrement: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (mem_wr ? addr == $past(addr) - 16'd1 : addr == $past(addr)));

    // R9: strobes are exclusive and appear only for the indirect select
    a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));
    a_r9_strobe_source: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (acc_en && sel == SEL_IND));
endmodule

bind addr_pair_reg addr_pair_reg_chk #(
    .SEL_W  (SEL_W),
    .SEL_HI (SEL_HI),
    .SEL_LO (SEL_LO),
    .SEL_IND(SEL_IND)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .acc_en(acc_en),
    .wr_en (wr_en),
    .sel   (sel),
    .din   (din),
    .dout  (dout),
    .addr  (addr),
    .mem_rd(mem_rd),
    .mem_wr(mem_wr)
);

// File: tb/addr_pair_reg_bench.sv
module addr_pair_reg_bench;
    localparam int CLK_P = 10;

    localparam logic [3:0] C_HI  = 4'b1011;
    localparam logic [3:0] C_LO  = 4'b1100;
    localparam logic [3:0] C_IND = 4'b1111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  sel = 4'b0000;
    logic [7:0]  din = 8'h00;
    logic [7:0]  dout;
    logic [15:0] addr;
    logic        mem_rd;
    logic        mem_wr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  s_dout;
    logic [15:0] s_addr;
    logic        s_rd;
    logic        s_wr;

    addr_pair_reg u_addr_pair_reg (
        .clk   (clk),
        .rst   (rst),
        .acc_en(acc_en),
        .wr_en (wr_en),
        .sel   (sel),
        .din   (din),
        .dout  (dout),
        .addr  (addr),
        .mem_rd(mem_rd),
        .mem_wr(mem_wr)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, sample during the cycle, end on posedge.
    task automatic access(input logic w, input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; wr_en = w; sel = s; din = d;
        #1;
        s_dout = dout; s_addr = addr; s_rd = mem_rd; s_wr = mem_wr;
        @(posedge clk);
        #1;
        acc_en = 1'b0; wr_en = 1'b0; sel = 4'b0000; din = 8'h00;
        #1;
    endtask

    task automatic load16(input logic [15:0] v);
        access(1'b1, C_HI, v[15:8]);
        access(1'b1, C_LO, v[7:0]);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #1 chk("R1 addr after reset", addr, 16'h0000);
        access(1'b0, C_HI, 8'h00);
        chk("R1 latch after reset", {8'h00, s_dout}, 16'h0000);
    endtask

    task automatic t_staging;
        load16(16'h1234);
        chk("R3 word load", addr, 16'h1234);
        access(1'b1, C_HI, 8'hAB);
        chk("R2 hi write staged only", addr, 16'h1234);
        access(1'b1, C_LO, 8'h56);
        chk("R3 lo write commits latch", addr, 16'hAB56);
    endtask

    task automatic t_snapshot;
        load16(16'h1234);
        access(1'b1, C_HI, 8'h77);
        access(1'b0, C_LO, 8'h00);
        chk("R4 lo read data", {8'h00, s_dout}, 16'h0034);
        access(1'b0, C_HI, 8'h00);
        chk("R4 lo read snapshots hi", {8'h00, s_dout}, 16'h0012);
        access(1'b1, C_HI, 8'h99);
        access(1'b0, C_HI, 8'h00);
        chk("R5 hi read returns latch", {8'h00, s_dout}, 16'h0099);
        chk("R5 live hi untouched", addr, 16'h1234);
    endtask

    task automatic t_ind_read;
        load16(16'h10FE);
        access(1'b0, C_IND, 8'h00);
        chk("R6 read addr during access", s_addr, 16'h10FE);
        chk("R6 R10 mem_rd on code 1111", {15'd0, s_rd}, 16'h0001);
        chk("R6 incremented", addr, 16'h10FF);
        access(1'b0, C_IND, 8'h00);
        chk("R8 carry into high byte", addr, 16'h1100);
    endtask

    task automatic t_ind_write;
        load16(16'h2000);
        access(1'b1, C_IND, 8'h00);
        chk("R7 predecremented addr", s_addr, 16'h1FFF);
        chk("R7 mem_wr strobe", {15'd0, s_wr}, 16'h0001);
        chk("R7 value after write", addr, 16'h1FFF);
        access(1'b1, C_IND, 8'h00);
        chk("R7 second push addr", s_addr, 16'h1FFE);
    endtask

    task automatic t_wrap;
        load16(16'hFFFF);
        access(1'b0, C_IND, 8'h00);
        chk("R8 increment wraps", addr, 16'h0000);
        access(1'b1, C_IND, 8'h00);
        chk("R8 decrement wraps addr", s_addr, 16'hFFFF);
        chk("R8 decrement wraps value", addr, 16'hFFFF);
    endtask

    task automatic t_ignore;
        load16(16'h4321);
        access(1'b1, 4'b1010, 8'h55);
        access(1'b1, 4'b1101, 8'h55);
        chk("R10 pointer codes foreign", addr, 16'h4321);
        access(1'b1, 4'b1110, 8'h55);
        chk("R9 no strobe on foreign code", {14'd0, s_rd, s_wr}, 16'h0000);
        chk("R9 value after foreign write", addr, 16'h4321);
        access(1'b0, 4'b0000, 8'h00);
        chk("R9 dout zero on foreign read", {8'h00, s_dout}, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; sel = C_LO; din = 8'hEE;
        @(posedge clk);
        #1 wr_en = 1'b0; sel = 4'b0000;
        chk("R9 no access without acc_en", addr, 16'h4321);
        access(1'b0, C_HI, 8'h00);
        chk("R9 latch untouched", {8'h00, s_dout}, 16'h0043);
    endtask

    initial begin
        t_reset();
        t_staging();
        t_snapshot();
        t_ind_read();
        t_ind_write();
        t_wrap();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule